// File: doc/BRIEF.md
# Stepped Current-Limit Soft-Start Sequencer

This block produces the digital current-limit level that a boost converter uses while it starts up. The level is given in ninths of full scale. It begins at one ninth and rises by one ninth per step. After eight steps it reaches full scale, and a completion flag is raised at that point. The time between steps is counted in pulses of a millisecond timebase. The number of pulses per interval is a parameter, which gives 2 ms in the target system and a short value in simulation.

A step is taken only if at least one LED string has carried current since the previous step. At low dimming duty cycles at low dimming frequencies, an interval can pass with no conduction at all. In that case the block waits with the interval complete and steps at the first sign of conduction. Lowering the LED enable returns everything to the starting level. When the enable rises again, a new sequence runs from the beginning with a fresh interval.

Top module: `softstart_seq`

## Requirements
- R1: During reset, and while `led_en` is low, `ilim_level` is 1 and `ilim_done` is 0.
- R2: `ilim_level` always lies between 1 and 9, where 9 means full current limit. Once it reaches 9 it stays at 9 however many further intervals pass.
- R3: Every change of level during a sequence is an increase of exactly one. Eight steps lead from 1 to 9.
- R4: An interval ends on the `TICKS_PER_STEP`-th `ms_tick` pulse counted from the last step or from enable. Pulses that arrive after the interval has ended, while the block waits for conduction, are not credited to the next interval.
- R5: A step requires `led_on` to have been high in at least one cycle since the previous step. Conduction seen before the previous step does not count toward the next one.
- R6: When an interval has ended without conduction, the level holds. It rises two clock cycles after the first cycle in which `led_on` is high.
- R7: A low `led_en` sets the level back to 1 on the next clock and discards any partly counted interval. After re-enable, the full sequence runs again.
- R8: `ilim_done` is high exactly when the level is 9. It stays high until `led_en` goes low.
- R9: While `led_en` is low, `ms_tick` and `led_on` have no effect. No tick or conduction seen during that time carries into the sequence after re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| led_en | input | 1 | LED enable; low holds the sequence at its start |
| led_on | input | 1 | High in a cycle in which any LED string conducts |
| ms_tick | input | 1 | One-cycle pulse from the millisecond timebase |
| ilim_level | output | LVL_W (4) | Current-limit level in ninths of full scale, 1 to 9 |
| ilim_done | output | 1 | High once full scale is reached |

## Verification
The hardest situation to reach from the ports is an interval that has fully elapsed while no conduction has occurred. The block then sits waiting while further timebase pulses arrive and must not credit them. The stimulus gets there by withholding `led_on` across a whole interval, adding surplus ticks, and then giving one single-cycle conduction pulse. It then checks that exactly a full fresh interval is needed for the following step. A related case is disabling part-way through an interval, which is reached by pulsing the enable low between ticks.

// File: rtl/sst_pkg.sv
package sst_pkg;

  localparam int unsigned SST_INIT_LEVEL = 1;

  // width able to hold the initial level plus every step
  function automatic int sst_lvl_width(input int steps);
    return $clog2(steps + 2);
  endfunction

  // width of a counter that reaches n-1
  function automatic int sst_cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sst_interval_timer.sv
module sst_interval_timer #(
  parameter int TICKS_PER_STEP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ms_tick,
  input  logic step,
  output logic due
);
  localparam int CNT_W = sst_pkg::sst_cnt_width(TICKS_PER_STEP);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_STEP - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             due_q, due_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    due_d  = due_q;
    cnt_en = 1'b0;
    if (!run) begin
      cnt_d  = '0;
      due_d  = 1'b0;
      cnt_en = 1'b1;
    end else if (step) begin
      cnt_d  = '0;
      due_d  = 1'b0;
      cnt_en = 1'b1;
    end else if (ms_tick && !due_q) begin
      cnt_en = 1'b1;
      if (cnt_q == LAST) begin
        cnt_d = '0;
        due_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      due_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      due_q <= due_d;
    end
  end

  assign due = due_q;

  // R4: count never passes the last tick of an interval
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R4: an ended interval stays ended until a step or disable
  p_due_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (due_q && run && !step) |=> due_q);

  // R7: disable discards interval progress
  p_due_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!due_q && cnt_q == '0));

endmodule

// File: rtl/sst_conduct_latch.sv
module sst_conduct_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic led_on,
  input  logic step,
  output logic seen
);
  logic seen_q, seen_d;

  always_comb begin
    if (!run || step) seen_d = 1'b0;
    else              seen_d = seen_q | led_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_d;
  end

  assign seen = seen_q;

  // R5: a step consumes the conduction record
  p_seen_consumed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !seen_q);

  // R9: nothing is recorded while disabled
  p_seen_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !seen_q);

endmodule

// File: rtl/sst_level_stepper.sv
module sst_level_stepper #(
  parameter int NUM_STEPS = 8,
  parameter int LVL_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             due,
  input  logic             seen,
  output logic             step,
  output logic [LVL_W-1:0] level,
  output logic             done
);
  localparam logic [LVL_W-1:0] INIT_L = LVL_W'(sst_pkg::SST_INIT_LEVEL);
  localparam logic [LVL_W-1:0] TOP_L  = LVL_W'(sst_pkg::SST_INIT_LEVEL + NUM_STEPS);
  localparam logic [LVL_W-1:0] PRE_L  = LVL_W'(sst_pkg::SST_INIT_LEVEL + NUM_STEPS - 1);

  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             done_q, done_d;
  logic             upd_en;

  assign step = run && due && seen && !done_q;

  always_comb begin
    lvl_d  = lvl_q;
    done_d = done_q;
    upd_en = 1'b0;
    if (!run) begin
      lvl_d  = INIT_L;
      done_d = 1'b0;
      upd_en = 1'b1;
    end else if (step) begin
      lvl_d  = lvl_q + 1'b1;
      done_d = (lvl_q == PRE_L);
      upd_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= INIT_L;
      done_q <= 1'b0;
    end else if (upd_en) begin
      lvl_q  <= lvl_d;
      done_q <= done_d;
    end
  end

  assign level = lvl_q;
  assign done  = done_q;

  // R2: level within the legal code range
  p_level_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q >= INIT_L) && (lvl_q <= TOP_L));

  // R3: during a run the level moves only upward by one
  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && lvl_q != $past(lvl_q)) |-> (lvl_q == $past(lvl_q) + 1'b1));

  // R5: a rise is preceded by recorded conduction and an ended interval
  p_gated_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && lvl_q != $past(lvl_q)) |-> ($past(seen) && $past(due)));

  // R7: disable returns to the initial level
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (lvl_q == INIT_L && !done_q));

  // R8: completion flag and full-scale level coincide
  p_done_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q == (lvl_q == TOP_L));

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq #(
  parameter int TICKS_PER_STEP = 2,
  parameter int NUM_STEPS      = 8,
  parameter int LVL_W          = sst_pkg::sst_lvl_width(NUM_STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             led_en,
  input  logic             led_on,
  input  logic             ms_tick,
  output logic [LVL_W-1:0] ilim_level,
  output logic             ilim_done
);
  logic due, seen, step;

  sst_interval_timer #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (led_en),
    .ms_tick (ms_tick),
    .step    (step),
    .due     (due)
  );

  sst_conduct_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (led_en),
    .led_on (led_on),
    .step   (step),
    .seen   (seen)
  );

  sst_level_stepper #(.NUM_STEPS(NUM_STEPS), .LVL_W(LVL_W)) u_step (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (led_en),
    .due   (due),
    .seen  (seen),
    .step  (step),
    .level (ilim_level),
    .done  (ilim_done)
  );

  // R1: initial level while disabled
  p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!led_en && !$past(led_en)) |-> (ilim_level == LVL_W'(1) && !ilim_done));

  // R8: completion holds while enabled
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim_done && led_en) |=> ilim_done);

endmodule

// File: tb/softstart_seq_test.sv
module softstart_seq_test;
  localparam int TPS = 3;
  localparam int NST = 8;
  localparam int LW  = 4;

  logic          clk = 1'b0;
  logic          rst_n, led_en, led_on, ms_tick;
  logic [LW-1:0] ilim_level;
  logic          ilim_done;
  int            n_chk = 0;
  int            n_bad = 0;

  always #10 clk = ~clk;

  softstart_seq #(.TICKS_PER_STEP(TPS), .NUM_STEPS(NST), .LVL_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .led_en(led_en), .led_on(led_on),
    .ms_tick(ms_tick), .ilim_level(ilim_level), .ilim_done(ilim_done)
  );

  task automatic chk(input string req, input int exp_lvl, input bit exp_done);
    n_chk++;
    if (ilim_level != LW'(exp_lvl) || ilim_done != exp_done) begin
      n_bad++;
      $display("FAIL %s: level=%0d done=%0d expected level=%0d done=%0d",
               req, ilim_level, ilim_done, exp_lvl, exp_done);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    ms_tick = 1'b1; cyc(1); ms_tick = 1'b0; cyc(1);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // R1
  task automatic t_reset();
    rst_n = 1'b0; led_en = 1'b0; led_on = 1'b0; ms_tick = 1'b0;
    cyc(3);
    chk("R1 in reset", 1, 1'b0);
    rst_n = 1'b1; cyc(2);
    chk("R1 after reset", 1, 1'b0);
  endtask

  // R3 R2 R8
  task automatic t_full_run();
    led_en = 1'b1; led_on = 1'b1; cyc(1);
    for (int s = 1; s <= NST; s++) begin
      ticks(TPS - 1);
      chk("R3 before interval end", s, 1'b0);
      tick();
      chk("R3 one step per interval", s + 1, s == NST);
    end
    ticks(3 * TPS);
    chk("R2 saturates at full scale", NST + 1, 1'b1);
    chk("R8 done holds while enabled", NST + 1, 1'b1);
    led_on = 1'b0;
  endtask

  // R7 R8
  task automatic t_restart_from_done();
    led_en = 1'b0; cyc(1);
    chk("R7 disable restores level 1", 1, 1'b0);
    chk("R8 done clears on disable", 1, 1'b0);
  endtask

  // R9 R5
  task automatic t_disabled_ignored();
    led_on = 1'b1; ticks(2 * TPS);
    chk("R9 ticks and conduction ignored while disabled", 1, 1'b0);
    led_on = 1'b0; led_en = 1'b1; cyc(1);
    ticks(TPS);
    chk("R5 no step without conduction in interval", 1, 1'b0);
  endtask

  // R6 R4
  task automatic t_wait_conduct();
    ticks(5);
    chk("R6 level holds while waiting", 1, 1'b0);
    led_on = 1'b1; cyc(1); led_on = 1'b0;
    chk("R6 no rise one cycle after conduction", 1, 1'b0);
    cyc(1);
    chk("R6 rise two cycles after conduction", 2, 1'b0);
    led_on = 1'b1;
    ticks(TPS - 1);
    chk("R4 surplus ticks not credited", 2, 1'b0);
    tick();
    chk("R4 fresh interval completes", 3, 1'b0);
    led_on = 1'b0;
  endtask

  // R5
  task automatic t_stale_conduct();
    ticks(TPS);
    chk("R5 conduction before last step does not count", 3, 1'b0);
    led_on = 1'b1; cyc(1); led_on = 1'b0; cyc(1);
    chk("R5 late conduction steps", 4, 1'b0);
    led_on = 1'b1; cyc(1); led_on = 1'b0;
    ticks(TPS);
    chk("R5 early conduction in interval counts", 5, 1'b0);
  endtask

  // R7
  task automatic t_partial_restart();
    led_on = 1'b1;
    ticks(TPS - 1);
    chk("R7 mid interval", 5, 1'b0);
    led_en = 1'b0; cyc(1);
    chk("R7 mid-interval disable", 1, 1'b0);
    led_en = 1'b1; cyc(1);
    tick();
    chk("R7 partial interval discarded", 1, 1'b0);
    ticks(TPS - 1);
    chk("R7 new sequence first step", 2, 1'b0);
    led_on = 1'b0;
  endtask

  initial begin
    t_reset();
    t_full_run();
    t_restart_from_done();
    t_disabled_ignored();
    t_wait_conduct();
    t_stale_conduct();
    t_partial_restart();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule